// File: doc/BRIEF.md
# Window Watchdog With Lead Time

This block supervises a host processor. Each tick of an external oscillator advances it through a sequence of timed phases. After any reset it opens a long lead phase in which the host has to deliver its first trigger. It then alternates two windows. In the closed window a trigger is forbidden. In the open window a trigger is mandatory. A trigger is a rising edge on the positive trigger pin or a falling edge on the negative trigger pin. Each trigger pin passes through a glitch filter before its edge counts, and that filter runs on a separate microsecond tick.

A violation produces a watchdog pulse of fixed length. The block combines that pulse with an external undervoltage reset into one low-active reset output. A debug input or a low-power indication turns supervision off. A wake strobe restarts the lead phase. The host uses this strobe after leaving a low-power state, at the falling edge of the receive line.

Top module: `window_watchdog`

## Requirements
- R1: During and directly after system reset, the block is in the lead phase, and `resetN` equals `uvResetN`.
- R2: A trigger is accepted only after the filtered level of a trigger pin has differed from its previous value for STABLE_TICKS consecutive `usTick` samples (default 3). With one tick per clock, a level held for 2 clocks is ignored, and a level held for 3 or more clocks is accepted 6 clock edges after the first edge that sees it.
- R3: The lead phase lasts LEAD_CYC oscillator ticks (3922). A trigger accepted during the lead phase starts a closed window at once.
- R4: When the lead phase expires without a trigger, a watchdog pulse starts. Every watchdog pulse holds `resetN` low for exactly PULSE_CYC ticks (157) and is followed by a new lead phase.
- R5: A trigger accepted during the closed window (CLOSED_CYC = 800 ticks) starts a watchdog pulse in the same cycle.
- R6: When the closed window ends, an open window of OPEN_CYC ticks (840) follows. A trigger in the open window starts a new closed window. If the open window ends without a trigger, a watchdog pulse starts.
- R7: `resetN` is low whenever `uvResetN` is low. Releasing `uvResetN` starts a fresh lead phase of LEAD_CYC ticks.
- R8: While `debugMode` or `lowPower` is high, no watchdog pulse occurs and `resetN` follows `uvResetN`. When both drop, a fresh lead phase is loaded on the first enabled edge.
- R9: A one-cycle `wakeStrobe` restarts the lead phase from its full length.
- R10: A trigger during a watchdog pulse is ignored, and the pulse keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| oscTick | input | 1 | One-cycle strobe per watchdog oscillator period |
| usTick | input | 1 | One-cycle strobe per microsecond, used by the trigger filter |
| trigPos | input | 1 | Trigger pin that counts on its rising edge |
| trigNeg | input | 1 | Trigger pin that counts on its falling edge (idles high) |
| uvResetN | input | 1 | Undervoltage reset, active low |
| debugMode | input | 1 | High turns supervision off |
| lowPower | input | 1 | High while in a low-power mode; turns supervision off |
| wakeStrobe | input | 1 | One-cycle strobe that restarts the lead phase |
| resetN | output | 1 | Combined reset output, active low |

## Verification
The bench services the watchdog with triggers spaced 1000 clocks apart, alternating the two trigger pins. It injects 2-clock glitches inside the closed windows, which tells a working filter apart from one that passes short pulses. A trigger placed deep inside the closed window separates immediate reset from deferred reset. An omitted trigger, once after the lead phase and once in an open window, exposes off-by-one errors in the window lengths. Further stimulus covers undervoltage, debug, low-power and wake events, and a trigger issued during a pulse; these show whether every reset cause reloads the lead phase and whether a pulse can be cut short.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [2:0] {
    PH_OFF,
    PH_LEAD,
    PH_CLOSED,
    PH_OPEN,
    PH_PULSE
  } wdPhase_e;

  typedef struct packed {
    logic     load;
    wdPhase_e sel;
  } wdStrobe_s;
endpackage

// File: rtl/trig_filter.sv
module trig_filter #(
  parameter int STABLE_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic rawIn,
  output logic rise
);
  localparam int CW = $clog2(STABLE_TICKS + 1);

  logic sync1, sync2, filtLevel;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      filtLevel <= 1'b0;
      runCnt    <= '0;
      rise      <= 1'b0;
    end else begin
      sync1 <= rawIn;
      sync2 <= sync1;
      rise  <= 1'b0;
      if (sync2 == filtLevel) begin
        runCnt <= '0;
      end else if (usTick) begin
        if (runCnt == CW'(STABLE_TICKS - 1)) begin
          filtLevel <= sync2;
          runCnt    <= '0;
          rise      <= sync2;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int LEAD_CYC   = 3922,
  parameter int CLOSED_CYC = 800,
  parameter int OPEN_CYC   = 840,
  parameter int PULSE_CYC  = 157
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      oscTick,
  input  wdStrobe_s strobe,
  output logic      lastTick
);
  localparam int MAX_A  = (LEAD_CYC > CLOSED_CYC) ? LEAD_CYC : CLOSED_CYC;
  localparam int MAX_B  = (OPEN_CYC > PULSE_CYC) ? OPEN_CYC : PULSE_CYC;
  localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic [CNT_W-1:0] remain;

  function automatic logic [CNT_W-1:0] lenOf(input wdPhase_e ph);
    case (ph)
      PH_CLOSED: lenOf = CNT_W'(CLOSED_CYC);
      PH_OPEN:   lenOf = CNT_W'(OPEN_CYC);
      PH_PULSE:  lenOf = CNT_W'(PULSE_CYC);
      default:   lenOf = CNT_W'(LEAD_CYC);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= CNT_W'(LEAD_CYC);
    end else if (strobe.load) begin
      remain <= lenOf(strobe.sel);
    end else if (oscTick && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign lastTick = oscTick && (remain == CNT_W'(1));
endmodule

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      trig,
  input  logic      lastTick,
  input  logic      uvResetN,
  input  logic      wdOff,
  input  logic      wake,
  output wdPhase_e  phase,
  output wdStrobe_s strobe
);
  wdPhase_e tgt;
  logic     jump;

  always_comb begin
    jump = 1'b0;
    tgt  = PH_LEAD;
    if (!uvResetN) begin
      jump = 1'b1;
    end else if (wdOff) begin
      tgt = PH_OFF;
    end else if (wake) begin
      jump = 1'b1;
    end else begin
      case (phase)
        PH_OFF: jump = 1'b1;
        PH_LEAD: begin
          if (trig)          begin jump = 1'b1; tgt = PH_CLOSED; end
          else if (lastTick) begin jump = 1'b1; tgt = PH_PULSE;  end
        end
        PH_CLOSED: begin
          if (trig)          begin jump = 1'b1; tgt = PH_PULSE; end
          else if (lastTick) begin jump = 1'b1; tgt = PH_OPEN;  end
        end
        PH_OPEN: begin
          if (trig)          begin jump = 1'b1; tgt = PH_CLOSED; end
          else if (lastTick) begin jump = 1'b1; tgt = PH_PULSE;  end
        end
        PH_PULSE: if (lastTick) jump = 1'b1;
        default:  jump = 1'b1;
      endcase
    end
  end

  assign strobe = '{load: jump, sel: tgt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          phase <= PH_LEAD;
    else if (jump || tgt == PH_OFF)     phase <= tgt;
  end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wd_pkg::*;
#(
  parameter int LEAD_CYC     = 3922,
  parameter int CLOSED_CYC   = 800,
  parameter int OPEN_CYC     = 840,
  parameter int PULSE_CYC    = 157,
  parameter int STABLE_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  input  logic usTick,
  input  logic trigPos,
  input  logic trigNeg,
  input  logic uvResetN,
  input  logic debugMode,
  input  logic lowPower,
  input  logic wakeStrobe,
  output logic resetN
);
  localparam int N_CH = 2;

  logic [N_CH-1:0] rawVec, riseVec;
  logic            trig, lastTick;
  wdPhase_e        phase;
  wdStrobe_s       strobe;

  assign rawVec = {~trigNeg, trigPos};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_filt
    trig_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .usTick (usTick),
      .rawIn  (rawVec[ch]),
      .rise   (riseVec[ch])
    );
  end

  assign trig = |riseVec;

  wd_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trig     (trig),
    .lastTick (lastTick),
    .uvResetN (uvResetN),
    .wdOff    (debugMode | lowPower),
    .wake     (wakeStrobe),
    .phase    (phase),
    .strobe   (strobe)
  );

  wd_datapath #(
    .LEAD_CYC   (LEAD_CYC),
    .CLOSED_CYC (CLOSED_CYC),
    .OPEN_CYC   (OPEN_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .strobe   (strobe),
    .lastTick (lastTick)
  );

  assign resetN = uvResetN & (phase != PH_PULSE);
endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk
  import wd_pkg::*;
#(
  parameter int PULSE_CYC = 157
) (
  input logic     clk,
  input logic     rstN,
  input logic     oscTick,
  input logic     uvResetN,
  input logic     debugMode,
  input logic     lowPower,
  input logic     wakeStrobe,
  input logic     resetN,
  input logic     trig,
  input logic     lastTick,
  input wdPhase_e phase
);
  localparam int PW = $clog2(PULSE_CYC + 2);

  logic           enabled;
  logic [PW-1:0]  pulseTicks;

  assign enabled = uvResetN && !debugMode && !lowPower && !wakeStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseTicks <= '0;
    else if (phase != PH_PULSE) pulseTicks <= '0;
    else if (oscTick)           pulseTicks <= pulseTicks + 1'b1;
  end

  // R7
  uv_forces_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uvResetN |-> !resetN);

  // R3
  lead_trig_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LEAD && trig && enabled) |=> (phase == PH_CLOSED));

  // R5
  closed_trig_resets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CLOSED && trig && enabled) |=> (phase == PH_PULSE));

  // R6
  open_trig_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OPEN && trig && enabled) |=> (phase == PH_CLOSED));

  // R8
  disabled_goes_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((debugMode || lowPower) && uvResetN) |=> (phase == PH_OFF));

  // R10
  pulse_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PULSE && enabled && !lastTick) |=> (phase == PH_PULSE));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseTicks <= PW'(PULSE_CYC));
endmodule

bind window_watchdog window_watchdog_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .oscTick    (oscTick),
  .uvResetN   (uvResetN),
  .debugMode  (debugMode),
  .lowPower   (lowPower),
  .wakeStrobe (wakeStrobe),
  .resetN     (resetN),
  .trig       (trig),
  .lastTick   (lastTick),
  .phase      (phase)
);

// File: tb/window_watchdog_tb.sv
module window_watchdog_tb;
  localparam int CLK_P  = 10;
  localparam int LEAD   = 3922;
  localparam int CLOSED = 800;
  localparam int OPEN   = 840;
  localparam int PULSE  = 157;
  localparam int FILT   = 3;

  localparam int M_OFF = 0, M_LEAD = 1, M_CLOSED = 2, M_OPEN = 3, M_PULSE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, oscTick = 1'b1, usTick = 1'b1;
  logic trigPos = 1'b0, trigNeg = 1'b1, uvResetN = 1'b1;
  logic debugMode = 1'b0, lowPower = 1'b0, wakeStrobe = 1'b0;
  logic resetN;

  int total = 0, fails = 0;
  bit finished = 0;
  string curReq = "R1";

  always #(CLK_P/2) clk = ~clk;

  window_watchdog u_dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .usTick(usTick),
    .trigPos(trigPos), .trigNeg(trigNeg), .uvResetN(uvResetN),
    .debugMode(debugMode), .lowPower(lowPower), .wakeStrobe(wakeStrobe),
    .resetN(resetN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mPh = M_LEAD, mRem = LEAD;
  bit  mPend = 0;
  bit  dA[2], dB[2], mLvl[2];
  int  mRun[2];
  bit  mExp;

  always @(posedge clk) begin
    bit x[2];
    bit v, newTrig, fin;
    if (!rstN) begin
      mPh = M_LEAD; mRem = LEAD; mPend = 0;
      for (int c = 0; c < 2; c++) begin dA[c] = 0; dB[c] = 0; mLvl[c] = 0; mRun[c] = 0; end
    end else begin
      fin = oscTick && (mRem == 1);
      if (!uvResetN) begin mPh = M_LEAD; mRem = LEAD; end
      else if (debugMode || lowPower) mPh = M_OFF;
      else if (wakeStrobe) begin mPh = M_LEAD; mRem = LEAD; end
      else begin
        case (mPh)
          M_OFF: begin mPh = M_LEAD; mRem = LEAD; end
          M_LEAD:
            if (mPend)    begin mPh = M_CLOSED; mRem = CLOSED; end
            else if (fin) begin mPh = M_PULSE;  mRem = PULSE;  end
            else if (oscTick) mRem--;
          M_CLOSED:
            if (mPend)    begin mPh = M_PULSE; mRem = PULSE; end
            else if (fin) begin mPh = M_OPEN;  mRem = OPEN;  end
            else if (oscTick) mRem--;
          M_OPEN:
            if (mPend)    begin mPh = M_CLOSED; mRem = CLOSED; end
            else if (fin) begin mPh = M_PULSE;  mRem = PULSE;  end
            else if (oscTick) mRem--;
          default:
            if (fin) begin mPh = M_LEAD; mRem = LEAD; end
            else if (oscTick) mRem--;
        endcase
      end
      x[0] = trigPos; x[1] = ~trigNeg;
      newTrig = 0;
      for (int c = 0; c < 2; c++) begin
        v = dB[c]; dB[c] = dA[c]; dA[c] = x[c];
        if (v == mLvl[c]) mRun[c] = 0;
        else if (usTick) begin
          mRun[c]++;
          if (mRun[c] == FILT) begin
            mLvl[c] = v; mRun[c] = 0;
            if (v) newTrig = 1;
          end
        end
      end
      mPend = newTrig;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    mExp = uvResetN && (mPh != M_PULSE);
    if (!finished) chk(resetN === mExp, curReq, int'(resetN), int'(mExp));
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #(CLK_P/4); end
  endtask

  task automatic watchLows(input int n, output int lows);
    lows = 0;
    repeat (n) begin @(posedge clk); #(CLK_P/4); if (!resetN) lows++; end
  endtask

  task automatic countUntilLow(output int n);
    n = 0;
    do begin @(posedge clk); #(CLK_P/4); n++; end while (resetN && n < 20000);
  endtask

  task automatic countLow(output int n);
    n = 1;
    forever begin
      @(posedge clk); #(CLK_P/4);
      if (resetN) break;
      n++;
    end
  endtask

  task automatic pulsePos(input int len);
    @(negedge clk) trigPos = 1'b1;
    repeat (len) @(negedge clk);
    trigPos = 1'b0;
  endtask

  task automatic pulseNeg(input int len);
    @(negedge clk) trigNeg = 1'b0;
    repeat (len) @(negedge clk);
    trigNeg = 1'b1;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; total++;
    $display("FAIL watchdog timeout: actual=running expected=done");
    summary();
  end

  // ---------------- scenarios ----------------
  initial begin
    int n, lows;
    idle(5);
    curReq = "R1";
    chk(resetN === 1'b1, "R1 reset state", int'(resetN), 1);
    @(negedge clk) rstN = 1'b1;
    curReq = "R3";
    countUntilLow(n);
    chk(n == LEAD, "R3 lead length", n, LEAD);

    curReq = "R10";
    fork pulsePos(8); join_none
    countLow(n);
    chk(n == PULSE, "R10 pulse length with trigger inside", n, PULSE);

    curReq = "R5";
    idle(100);
    pulsePos(8);
    idle(200);
    fork pulseNeg(8); join_none
    countUntilLow(n);
    chk(n == 6, "R5 closed-window trigger latency", n, 6);
    curReq = "R4";
    countLow(n);
    chk(n == PULSE, "R4 pulse length", n, PULSE);

    curReq = "R6";
    idle(50);
    for (int r = 0; r < 4; r++) begin
      if (r % 2 == 0) fork pulsePos(8); join_none
      else            fork pulseNeg(8); join_none
      watchLows(100, lows);
      chk(lows == 0, "R6 serviced window", lows, 0);
      curReq = "R2";
      if (r % 2 == 0) fork pulseNeg(2); join_none
      else            fork pulsePos(2); join_none
      watchLows(900, lows);
      chk(lows == 0, "R2 glitch in closed window ignored", lows, 0);
      curReq = "R6";
    end
    countUntilLow(n);
    chk(n == OPEN + CLOSED + 5 - 999, "R6 open-window expiry", n, OPEN + CLOSED + 5 - 999);
    countLow(n);
    chk(n == PULSE, "R4 pulse after open expiry", n, PULSE);

    curReq = "R7";
    idle(20);
    @(negedge clk) uvResetN = 1'b0;
    @(posedge clk); #(CLK_P/4);
    chk(resetN === 1'b0, "R7 undervoltage forces reset", int'(resetN), 0);
    idle(50);
    @(negedge clk) uvResetN = 1'b1;
    countUntilLow(n);
    chk(n == LEAD, "R7 fresh lead after undervoltage", n, LEAD);
    countLow(n);

    curReq = "R8";
    @(negedge clk) debugMode = 1'b1;
    watchLows(5000, lows);
    chk(lows == 0, "R8 debug disables watchdog", lows, 0);
    @(negedge clk) debugMode = 1'b0;
    countUntilLow(n);
    chk(n == LEAD + 1, "R8 lead after debug exit", n, LEAD + 1);
    countLow(n);

    curReq = "R9";
    @(negedge clk) lowPower = 1'b1;
    watchLows(200, lows);
    chk(lows == 0, "R8 low power disables watchdog", lows, 0);
    @(negedge clk) lowPower = 1'b0;
    watchLows(3000, lows);
    chk(lows == 0, "R9 lead running before wake", lows, 0);
    @(negedge clk) wakeStrobe = 1'b1;
    fork begin @(negedge clk) wakeStrobe = 1'b0; end join_none
    countUntilLow(n);
    chk(n == LEAD + 1, "R9 wake restarts lead", n, LEAD + 1);
    countLow(n);
    chk(n == PULSE, "R4 pulse after wake lead", n, PULSE);
    idle(10);
    summary();
  end
endmodule